// File: doc/BRIEF.md
# LIN Break-In Detector

This block watches the sampled receive line of a LIN node, including while a response byte is in flight, and finds a new header: a long dominant break, a recessive delimiter, and the synchronisation byte 0x55. A break can start part way through a response byte. Once the break and sync are confirmed, the block strobes the start of a new frame. In slave mode it also tells the transfer logic to drop the response. The error it raises depends on whether the node was sending or receiving when the break began.

In master mode the block never aborts a response on its own. Software ends a transfer by writing the abort command, which raises an abort flag and pulses the transfer-abort output. The block measures the break with the bit length that was in force for the response being interrupted. It does not use a value changed mid-response. All flags are sticky until a write-one clear. The block has no data stream, so every pin is plain control or status.

Top module: `lin_brk_det`

## Requirements
- R1: After reset `berr`, `ferr`, `abort_flag`, `frame_abort` and `new_frame` are all 0.
- R2: A run of at least BRK_BITS (11) dominant bit times (rx=0), then at least one recessive bit time, then a byte with start bit 0, data 0x55 sent LSB first and stop bit 1, gives a one-clock `new_frame` pulse. A dominant run of 10 bit times gives no pulse.
- R3: In slave mode (`is_master`=0), if `resp_active`=1 and `resp_tx`=0 when the break's dominant run began, sync confirmation sets `ferr` and pulses `frame_abort` once.
- R4: In slave mode, if `resp_active`=1 and `resp_tx`=1 when the break began, sync confirmation sets `berr` and pulses `frame_abort` once.
- R5: A break and sync seen while no response was active pulse `new_frame` but set no flag and give no `frame_abort`.
- R6: If the byte after the delimiter is not a valid 0x55 frame, `ferr` is set and neither `new_frame` nor `frame_abort` is pulsed.
- R7: In master mode a break-in during a response sets neither `berr` nor `ferr` and gives no `frame_abort`. It still pulses `new_frame`.
- R8: In master mode, a one-clock `sw_cmd_wr` with `sw_cmd`=2'b00 (abort) while `resp_active`=1 sets `abort_flag` and pulses `frame_abort`. Any other command, slave mode, or no active response leaves both unchanged.
- R9: The bit length (clocks per bit) used for timing follows `bit_time` only while no response is active. A change made during a response has no effect until that response ends.
- R10: Each flag stays set until its own clear input is 1 for a clock. A clear affects only its own flag, and a set in the same clock wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Sampled bus line, 0 dominant |
| bit_time | input | BT_W | Clocks per bit, at least 2 |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| resp_active | input | 1 | A response is in progress |
| resp_tx | input | 1 | The response is being sent by this node |
| sw_cmd_wr | input | 1 | One-clock command write strobe |
| sw_cmd | input | 2 | Command code, 2'b00 = abort |
| clr_berr | input | 1 | Write-one clear of `berr` |
| clr_ferr | input | 1 | Write-one clear of `ferr` |
| clr_abort | input | 1 | Write-one clear of `abort_flag` |
| berr | output | 1 | Bit error: a response being sent was broken into |
| ferr | output | 1 | Framing error: a received response was broken into, or the sync byte was bad |
| abort_flag | output | 1 | Set by a software abort |
| frame_abort | output | 1 | One-clock pulse: drop the transfer in progress |
| new_frame | output | 1 | One-clock pulse: a new header has started |

## Verification
On every cycle the assertions check four things. `new_frame` never lasts two clocks, and `berr` never rises in master mode. Flags hold until cleared, and `abort_flag` only rises after a master abort command issued during a response. Only the bench scenarios can show the rest. These are the break-length threshold, sampling of the sync byte, the split between bit and framing errors for a break that overlaps a partial response byte, and the freezing of the bit length during a response.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef enum logic [0:0] {M_IDLE, M_DELIM} meas_st_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SAMP} sync_st_e;
  localparam logic [1:0] CMD_ABORT = 2'b00;
  localparam int FRAME_BITS = 10;
endpackage

// File: rtl/lin_brk_meas.sv
module lin_brk_meas
  import lin_brk_pkg::*;
#(
  parameter int BT_W     = 8,
  parameter int BRK_BITS = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic            hold,
  input  logic [BT_W-1:0] bit_time,
  input  logic            resp_active,
  input  logic            resp_tx,
  output logic [BT_W-1:0] bl,
  output logic            brk_ok,
  output logic            ctx_act,
  output logic            ctx_tx
);
  localparam int CNT_W = BT_W + $clog2(BRK_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_st_e         st;
  logic [CNT_W-1:0] lowcnt;
  logic [BT_W-1:0]  hcnt;
  logic [CNT_W-1:0] thr;

  assign thr    = CNT_W'(bl) * CNT_W'(BRK_BITS);
  assign brk_ok = !hold && (st == M_DELIM) && rx && (hcnt >= bl - BT_W'(1));

  // bit length frozen while a response runs or a low run is being timed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bl <= '0;
    else if (!resp_active && st == M_IDLE && lowcnt == '0 && !hold) bl <= bit_time;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      lowcnt  <= '0;
      hcnt    <= '0;
      ctx_act <= 1'b0;
      ctx_tx  <= 1'b0;
    end else if (hold) begin
      st     <= M_IDLE;
      lowcnt <= '0;
    end else begin
      case (st)
        M_IDLE: begin
          if (!rx) begin
            if (lowcnt == '0) begin
              ctx_act <= resp_active;
              ctx_tx  <= resp_tx;
            end
            if (lowcnt != CNT_MAX) lowcnt <= lowcnt + CNT_W'(1);
          end else begin
            if (lowcnt >= thr && lowcnt != '0) begin
              st   <= M_DELIM;
              hcnt <= BT_W'(1);
            end
            lowcnt <= '0;
          end
        end
        default: begin
          if (!rx) begin
            st      <= M_IDLE;
            lowcnt  <= CNT_W'(1);
            ctx_act <= resp_active;
            ctx_tx  <= resp_tx;
          end else if (brk_ok) begin
            st <= M_IDLE;
          end else begin
            hcnt <= hcnt + BT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lin_brk_sync.sv
module lin_brk_sync
  import lin_brk_pkg::*;
#(
  parameter int         BT_W      = 8,
  parameter logic [7:0] SYNC_BYTE = 8'h55
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic            arm,
  input  logic [BT_W-1:0] bl,
  output logic            busy,
  output logic            sync_ok,
  output logic            sync_bad
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  sync_st_e                st;
  logic [BT_W-1:0]         cnt;
  logic [IDX_W-1:0]        idx;
  logic [FRAME_BITS-1:0]   sh, sh_n;
  logic                    samp, last, good;

  assign busy = (st != S_IDLE);
  assign samp = (st == S_SAMP) && (cnt == '0);
  assign last = samp && (idx == IDX_W'(FRAME_BITS - 1));
  assign sh_n = {rx, sh[FRAME_BITS-1:1]};
  assign good = !sh_n[0] && sh_n[FRAME_BITS-1] && (sh_n[8:1] == SYNC_BYTE);
  assign sync_ok  = last && good;
  assign sync_bad = last && !good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_IDLE: if (arm) st <= S_WAIT;
        S_WAIT: if (!rx) begin
          st  <= S_SAMP;
          cnt <= (bl >> 1) - BT_W'(1);
          idx <= '0;
        end
        default: begin
          if (samp) begin
            sh  <= sh_n;
            cnt <= bl - BT_W'(1);
            idx <= idx + IDX_W'(1);
            if (last) st <= S_IDLE;
          end else begin
            cnt <= cnt - BT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lin_brk_flags.sv
module lin_brk_flags
  import lin_brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_ok,
  input  logic       sync_bad,
  input  logic       ctx_act,
  input  logic       ctx_tx,
  input  logic       is_master,
  input  logic       resp_active,
  input  logic       sw_cmd_wr,
  input  logic [1:0] sw_cmd,
  input  logic       clr_berr,
  input  logic       clr_ferr,
  input  logic       clr_abort,
  output logic       berr,
  output logic       ferr,
  output logic       abort_flag,
  output logic       frame_abort,
  output logic       new_frame
);
  logic slv_hit, sw_abort, set_b, set_f;

  assign slv_hit  = sync_ok && !is_master && ctx_act;
  assign sw_abort = is_master && resp_active && sw_cmd_wr && (sw_cmd == CMD_ABORT);
  assign set_b    = slv_hit && ctx_tx;
  assign set_f    = (slv_hit && !ctx_tx) || sync_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr        <= 1'b0;
      ferr        <= 1'b0;
      abort_flag  <= 1'b0;
      frame_abort <= 1'b0;
      new_frame   <= 1'b0;
    end else begin
      berr        <= set_b    | (berr & ~clr_berr);
      ferr        <= set_f    | (ferr & ~clr_ferr);
      abort_flag  <= sw_abort | (abort_flag & ~clr_abort);
      frame_abort <= slv_hit | sw_abort;
      new_frame   <= sync_ok;
    end
  end
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int         BT_W      = 8,
  parameter int         BRK_BITS  = 11,
  parameter logic [7:0] SYNC_BYTE = 8'h55
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic [BT_W-1:0] bit_time,
  input  logic            is_master,
  input  logic            resp_active,
  input  logic            resp_tx,
  input  logic            sw_cmd_wr,
  input  logic [1:0]      sw_cmd,
  input  logic            clr_berr,
  input  logic            clr_ferr,
  input  logic            clr_abort,
  output logic            berr,
  output logic            ferr,
  output logic            abort_flag,
  output logic            frame_abort,
  output logic            new_frame
);
  logic [BT_W-1:0] bl;
  logic brk_ok, ctx_act, ctx_tx, busy, sync_ok, sync_bad;

  lin_brk_meas #(.BT_W(BT_W), .BRK_BITS(BRK_BITS)) u_meas (
    .clk(clk), .rst_n(rst_n), .rx(rx), .hold(busy), .bit_time(bit_time),
    .resp_active(resp_active), .resp_tx(resp_tx), .bl(bl), .brk_ok(brk_ok),
    .ctx_act(ctx_act), .ctx_tx(ctx_tx)
  );

  lin_brk_sync #(.BT_W(BT_W), .SYNC_BYTE(SYNC_BYTE)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx(rx), .arm(brk_ok), .bl(bl), .busy(busy),
    .sync_ok(sync_ok), .sync_bad(sync_bad)
  );

  lin_brk_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sync_ok(sync_ok), .sync_bad(sync_bad),
    .ctx_act(ctx_act), .ctx_tx(ctx_tx), .is_master(is_master),
    .resp_active(resp_active), .sw_cmd_wr(sw_cmd_wr), .sw_cmd(sw_cmd),
    .clr_berr(clr_berr), .clr_ferr(clr_ferr), .clr_abort(clr_abort),
    .berr(berr), .ferr(ferr), .abort_flag(abort_flag),
    .frame_abort(frame_abort), .new_frame(new_frame)
  );
endmodule

// File: rtl/lin_brk_det_chk.sv
module lin_brk_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       is_master,
  input logic       resp_active,
  input logic       sw_cmd_wr,
  input logic [1:0] sw_cmd,
  input logic       clr_berr,
  input logic       clr_abort,
  input logic       berr,
  input logic       abort_flag,
  input logic       new_frame
);
  p_nf_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_frame |=> !new_frame);

  p_master_no_berr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(berr) |-> !$past(is_master));

  p_berr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (berr && !clr_berr) |=> berr);

  p_abort_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_flag && !clr_abort) |=> abort_flag);

  p_abort_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_flag) |-> $past(is_master && resp_active && sw_cmd_wr && (sw_cmd == 2'b00)));
endmodule

bind lin_brk_det lin_brk_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master), .resp_active(resp_active),
  .sw_cmd_wr(sw_cmd_wr), .sw_cmd(sw_cmd), .clr_berr(clr_berr),
  .clr_abort(clr_abort), .berr(berr), .abort_flag(abort_flag),
  .new_frame(new_frame)
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb;
  localparam int BL = 4;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [7:0] bit_time = 8'(BL);
  logic is_master = 1'b0, resp_active = 1'b0, resp_tx = 1'b0;
  logic sw_cmd_wr = 1'b0, clr_berr = 1'b0, clr_ferr = 1'b0, clr_abort = 1'b0;
  logic [1:0] sw_cmd = 2'b00;
  logic berr, ferr, abort_flag, frame_abort, new_frame;
  int checks = 0, fails = 0, nf_cnt = 0, fab_cnt = 0;

  always #2 clk = ~clk;

  lin_brk_det u_dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .bit_time(bit_time), .is_master(is_master),
    .resp_active(resp_active), .resp_tx(resp_tx), .sw_cmd_wr(sw_cmd_wr),
    .sw_cmd(sw_cmd), .clr_berr(clr_berr), .clr_ferr(clr_ferr),
    .clr_abort(clr_abort), .berr(berr), .ferr(ferr), .abort_flag(abort_flag),
    .frame_abort(frame_abort), .new_frame(new_frame)
  );

  always @(negedge clk) begin
    if (new_frame) nf_cnt++;
    if (frame_abort) fab_cnt++;
  end

  // {master, act, tx, break bits[4:0], sync[7:0], exp nf, berr, ferr, frame_abort}
  localparam logic [19:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b0, 5'd13, 8'h55, 4'b1011},  // R3 rx break-in
    {1'b0, 1'b1, 1'b1, 5'd12, 8'h55, 4'b1101},  // R4 tx break-in
    {1'b0, 1'b0, 1'b0, 5'd11, 8'h55, 4'b1000},  // R5 R2 exact length
    {1'b0, 1'b1, 1'b0, 5'd10, 8'h55, 4'b0000},  // R2 too short
    {1'b0, 1'b1, 1'b0, 5'd13, 8'h54, 4'b0010},  // R6 bad sync
    {1'b1, 1'b1, 1'b1, 5'd13, 8'h55, 4'b1000}   // R7 master
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int nbits);
    rx = v;
    repeat (nbits * BL) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    hold(1'b0, 1);
    for (int i = 0; i < 8; i++) hold(b[i], 1);
    hold(1'b1, 1);
  endtask

  task automatic clear_all();
    clr_berr = 1'b1; clr_ferr = 1'b1; clr_abort = 1'b1;
    @(negedge clk);
    clr_berr = 1'b0; clr_ferr = 1'b0; clr_abort = 1'b0;
    @(negedge clk);
    nf_cnt = 0; fab_cnt = 0;
  endtask

  task automatic sw_write(input logic [1:0] c);
    sw_cmd = c; sw_cmd_wr = 1'b1;
    @(negedge clk);
    sw_cmd_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 berr", berr, 0); chk("R1 ferr", ferr, 0);
    chk("R1 abort_flag", abort_flag, 0); chk("R1 frame_abort", frame_abort, 0);
    chk("R1 new_frame", new_frame, 0);
    rst_n = 1'b1;
    hold(1'b1, 3);

    foreach (VEC[k]) begin
      is_master = VEC[k][19]; resp_active = VEC[k][18]; resp_tx = VEC[k][17];
      hold(1'b1, 2);
      if (VEC[k][18]) begin hold(1'b0, 1); hold(1'b1, 1); end  // partial response byte
      hold(1'b0, int'(VEC[k][16:12]));
      hold(1'b1, 1);
      send_byte(VEC[k][11:4]);
      hold(1'b1, 2);
      chk($sformatf("R2 vec%0d new_frame count", k), nf_cnt, int'(VEC[k][3]));
      chk($sformatf("R4 vec%0d berr", k), berr, int'(VEC[k][2]));
      chk($sformatf("R3 vec%0d ferr", k), ferr, int'(VEC[k][1]));
      chk($sformatf("R6 vec%0d frame_abort count", k), fab_cnt, int'(VEC[k][0]));
      resp_active = 1'b0; is_master = 1'b0;
      clear_all();
    end

    // R9: bit length frozen during a response
    resp_active = 1'b1; resp_tx = 1'b0; bit_time = 8'd8;
    hold(1'b1, 2); hold(1'b0, 11); hold(1'b1, 1); send_byte(8'h55); hold(1'b1, 2);
    chk("R9 frozen length new_frame", nf_cnt, 1);
    chk("R9 frozen length ferr", ferr, 1);
    // R10: clearing berr leaves ferr set
    clr_berr = 1'b1; @(negedge clk); clr_berr = 1'b0; @(negedge clk);
    chk("R10 ferr kept after other clear", ferr, 1);
    clr_ferr = 1'b1; @(negedge clk); clr_ferr = 1'b0; @(negedge clk);
    chk("R10 ferr cleared", ferr, 0);
    resp_active = 1'b0;
    clear_all();
    hold(1'b1, 1);
    // R9: new length followed when idle; 11 bits at 4 clocks is now too short
    hold(1'b0, 11); hold(1'b1, 1); send_byte(8'h55); hold(1'b1, 2);
    chk("R9 followed length no new_frame", nf_cnt, 0);
    bit_time = 8'(BL);
    hold(1'b1, 2);
    clear_all();

    // R8: software abort
    is_master = 1'b0; resp_active = 1'b1;
    sw_write(2'b00);
    chk("R8 slave abort ignored", abort_flag, 0);
    chk("R8 slave abort no frame_abort", fab_cnt, 0);
    is_master = 1'b1;
    sw_write(2'b01);
    chk("R8 other cmd ignored", abort_flag, 0);
    resp_active = 1'b0;
    sw_write(2'b00);
    chk("R8 no response ignored", abort_flag, 0);
    resp_active = 1'b1;
    sw_write(2'b00);
    chk("R8 master abort flag", abort_flag, 1);
    chk("R8 master abort frame_abort", fab_cnt, 1);
    repeat (3) @(negedge clk);
    chk("R10 abort_flag sticky", abort_flag, 1);
    clr_abort = 1'b1; @(negedge clk); clr_abort = 1'b0; @(negedge clk);
    chk("R10 abort_flag cleared", abort_flag, 0);
    resp_active = 1'b0; is_master = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule